// File: doc/BRIEF.md
# Dual-Channel Edge Capture Unit with Counter Cascade

This block timestamps transitions on two digital input lines using down-counters that also serve as the timers of two PWM channels. Each channel has its own 16-bit down-counter. While the counter runs, it decrements once per clock and loads its period value again after it reaches zero. When capture is enabled on a channel, every rising transition of that channel's input copies the counter into a rising-edge latch, and every falling transition copies it into a falling-edge latch. The two latches are separate, so a pulse width or a period can be derived from a pair of stored values.

Each channel has a sticky interrupt flag. Rising and falling captures set it through separate enables. An optional mode reloads the channel counter on each rising capture, so the stored values measure time from the previous rising edge. A cascade control joins the two counters into one 32-bit counter for channel 0. In that mode channel 1 acts only as the upper half of the counter.

The counters must already be configured through the run and period inputs before capture is enabled. The inputs are asynchronous to the clock and are synchronised inside the block.

Top module: `cap_capture_unit`

## Requirements
- R1: While `rst_ni` is low, every counter, every latch and both flags read zero, whatever the other inputs do.
- R2: An input change first sampled at clock edge n is captured at edge n+2. The latch takes the counter value that was present just before edge n+2 and shows it after that edge.
- R3: With capture enabled, a 0-to-1 transition of `cap_i[c]` stores the channel value in `rise_lat_o[c]`. With no such capture the rising latch holds its value.
- R4: With capture enabled, a 1-to-0 transition of `cap_i[c]` stores the channel value in `fall_lat_o[c]`. With no such capture the falling latch holds its value.
- R5: While `cap_en_i[c]` is 0, transitions on `cap_i[c]` change neither latch of that channel nor its flag.
- R6: `cap_flag_o[c]` is set by a rising capture only when `rise_ie_i[c]` is 1, and by a falling capture only when `fall_ie_i[c]` is 1. The latches update regardless of these enables.
- R7: A set flag stays set until a cycle with `flag_clr_i[c]` high. If a capture that sets the flag coincides with the clear, the flag stays set.
- R8: Outside cascade mode, a running counter that is not reloaded counts down by one each clock. On a zero value it loads its 16-bit field of `period_i` (channel c uses bits [16c+15:16c]). A stopped counter holds its value.
- R9: When `reload_en_i[c]` is 1, a rising capture on channel c loads that channel's counter from its period field (the whole 32 bits in cascade mode) on the same edge. The latch receives the value from before the load.
- R10: With `cascade_i` high, `cnt_o` runs as one 32-bit down-counter under `run_i[0]`, with channel 1 as the upper half. The upper half changes only when the lower half steps from 0 to 0xFFFF. The whole 32 bits reload from `period_i` after reaching zero.
- R11: In cascade mode the channel 0 latches store all 32 counter bits. Outside cascade mode the upper 16 bits stored by a capture are zero.
- R12: While `cascade_i` is high, channel 1's latches hold their values and channel 1 captures neither set its flag nor reload a counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| run_i | input | 2 | Per-channel counter run enable (bit 0 runs the whole counter in cascade) |
| period_i | input | 32 | Reload values, channel 0 in [15:0], channel 1 in [31:16] |
| cascade_i | input | 1 | Join both counters into one 32-bit counter for channel 0 |
| cap_en_i | input | 2 | Per-channel capture enable |
| reload_en_i | input | 2 | Per-channel reload-on-rising-capture enable |
| rise_ie_i | input | 2 | Per-channel flag enable for rising captures |
| fall_ie_i | input | 2 | Per-channel flag enable for falling captures |
| flag_clr_i | input | 2 | Per-channel flag clear, write-one pulse |
| cap_i | input | 2 | Asynchronous capture inputs |
| cnt_o | output | 32 | Counter values, channel 0 in [15:0], channel 1 in [31:16] |
| rise_lat_o | output | 64 | Rising-edge latches, channel 0 in [31:0], channel 1 in [63:32] |
| fall_lat_o | output | 64 | Falling-edge latches, channel 0 in [31:0], channel 1 in [63:32] |
| cap_flag_o | output | 2 | Sticky per-channel capture flags |

## Verification
The assertions take the configuration inputs (run, period, cascade and the enables) to be changed only by a synchronous driver. They also take the reset to be released away from a clock edge, so that counter steps and latch holds can be judged from one edge to the next. The bench drives every input at the falling clock edge and changes the configuration only between test phases. It enters cascade mode by forcing a rising capture with reload enabled, so the 32-bit count starts from a known period and wraps within the run. The capture inputs toggle from a pseudo-random sequence, and a gap of several cycles is held around each directed edge so that the two-stage delay is measured cleanly.

// File: rtl/cap_pkg.sv
`timescale 1ns/1ps
package cap_pkg;
  localparam int unsigned CAP_NCH = 2;

  // One-cycle edge indications produced after synchronisation
  typedef struct packed {
    logic rise;
    logic fall;
  } cap_edge_t;
endpackage

// File: rtl/cap_edge_det.sv
`timescale 1ns/1ps
module cap_edge_det #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             din_i,
  output cap_pkg::cap_edge_t edge_o
);
  localparam int unsigned TOP = SYNC_STAGES - 1;

  logic [TOP:0] sync_q, sync_d;
  logic         prev_q, prev_d;

  always_comb begin
    sync_d[0] = din_i;
    for (int k = 1; k <= int'(TOP); k++) begin
      sync_d[k] = sync_q[k-1];
    end
    prev_d = sync_q[TOP];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= prev_d;
    end
  end

  assign edge_o.rise = sync_q[TOP] & ~prev_q;
  assign edge_o.fall = ~sync_q[TOP] & prev_q;
endmodule

// File: rtl/cap_timer_pair.sv
`timescale 1ns/1ps
module cap_timer_pair #(
  parameter int unsigned CW = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [1:0]      run_i,
  input  logic [2*CW-1:0] period_i,
  input  logic            cascade_i,
  input  logic [1:0]      reload_i,
  output logic [2*CW-1:0] cnt_o
);
  localparam int unsigned PW = 2 * CW;
  localparam logic [CW-1:0] ONE = CW'(1);

  logic [PW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [CW-1:0] lo_q, hi_q;

  assign lo_q = cnt_q[CW-1:0];
  assign hi_q = cnt_q[PW-1:CW];

  always_comb begin
    cnt_d = cnt_q;
    if (cascade_i) begin
      // Joined counter: lower half steps every clock, upper on lower wrap
      if (reload_i[0]) begin
        cnt_d = period_i;
      end else if (run_i[0]) begin
        if (cnt_q == '0) begin
          cnt_d = period_i;
        end else begin
          cnt_d[CW-1:0] = lo_q - ONE;
          if (lo_q == '0) cnt_d[PW-1:CW] = hi_q - ONE;
        end
      end
    end else begin
      for (int ch = 0; ch < 2; ch++) begin
        if (reload_i[ch]) begin
          cnt_d[ch*CW +: CW] = period_i[ch*CW +: CW];
        end else if (run_i[ch]) begin
          if (cnt_q[ch*CW +: CW] == '0) cnt_d[ch*CW +: CW] = period_i[ch*CW +: CW];
          else                          cnt_d[ch*CW +: CW] = cnt_q[ch*CW +: CW] - ONE;
        end
      end
    end
    cnt_en = (cnt_d != cnt_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/cap_latch_chan.sv
`timescale 1ns/1ps
module cap_latch_chan #(
  parameter int unsigned LW = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  cap_pkg::cap_edge_t edge_i,
  input  logic               en_i,
  input  logic               rise_ie_i,
  input  logic               fall_ie_i,
  input  logic               clr_i,
  input  logic [LW-1:0]      value_i,
  output logic [LW-1:0]      rise_lat_o,
  output logic [LW-1:0]      fall_lat_o,
  output logic               flag_o
);
  logic [LW-1:0] rise_q, fall_q;
  logic          flag_q, flag_d, flag_set;
  logic          rise_hit, fall_hit;

  always_comb begin
    rise_hit = edge_i.rise & en_i;
    fall_hit = edge_i.fall & en_i;
    flag_set = (rise_hit & rise_ie_i) | (fall_hit & fall_ie_i);
    flag_d   = flag_set | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= '0;
      fall_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (rise_hit) rise_q <= value_i;
      if (fall_hit) fall_q <= value_i;
      flag_q <= flag_d;
    end
  end

  assign rise_lat_o = rise_q;
  assign fall_lat_o = fall_q;
  assign flag_o     = flag_q;
endmodule

// File: rtl/cap_capture_unit.sv
`timescale 1ns/1ps
module cap_capture_unit #(
  parameter int unsigned CW          = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        run_i,
  input  logic [2*CW-1:0]   period_i,
  input  logic              cascade_i,
  input  logic [1:0]        cap_en_i,
  input  logic [1:0]        reload_en_i,
  input  logic [1:0]        rise_ie_i,
  input  logic [1:0]        fall_ie_i,
  input  logic [1:0]        flag_clr_i,
  input  logic [1:0]        cap_i,
  output logic [2*CW-1:0]   cnt_o,
  output logic [4*CW-1:0]   rise_lat_o,
  output logic [4*CW-1:0]   fall_lat_o,
  output logic [1:0]        cap_flag_o
);
  localparam int unsigned LW = 2 * CW;

  cap_pkg::cap_edge_t edge_v [cap_pkg::CAP_NCH];
  logic [LW-1:0]      value_v [cap_pkg::CAP_NCH];
  logic [1:0]         rise_v, en_eff, reload_v;

  cap_timer_pair #(.CW(CW)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .run_i     (run_i),
    .period_i  (period_i),
    .cascade_i (cascade_i),
    .reload_i  (reload_v),
    .cnt_o     (cnt_o)
  );

  for (genvar g = 0; g < int'(cap_pkg::CAP_NCH); g++) begin : g_chan
    cap_edge_det #(.SYNC_STAGES(SYNC_STAGES)) i_edge (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .din_i  (cap_i[g]),
      .edge_o (edge_v[g])
    );

    if (g == 0) begin : g_low
      assign en_eff[g]  = cap_en_i[g];
      assign value_v[g] = cascade_i ? cnt_o : {{CW{1'b0}}, cnt_o[CW-1:0]};
    end else begin : g_high
      // Channel 1 gives its counter away while cascaded
      assign en_eff[g]  = cap_en_i[g] & ~cascade_i;
      assign value_v[g] = {{CW{1'b0}}, cnt_o[LW-1:CW]};
    end

    assign rise_v[g]   = edge_v[g].rise;
    assign reload_v[g] = edge_v[g].rise & en_eff[g] & reload_en_i[g];

    cap_latch_chan #(.LW(LW)) i_latch (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .edge_i     (edge_v[g]),
      .en_i       (en_eff[g]),
      .rise_ie_i  (rise_ie_i[g]),
      .fall_ie_i  (fall_ie_i[g]),
      .clr_i      (flag_clr_i[g]),
      .value_i    (value_v[g]),
      .rise_lat_o (rise_lat_o[g*LW +: LW]),
      .fall_lat_o (fall_lat_o[g*LW +: LW]),
      .flag_o     (cap_flag_o[g])
    );
  end
endmodule

// File: rtl/cap_capture_chk.sv
`timescale 1ns/1ps
module cap_capture_chk #(
  parameter int unsigned CW = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cascade_i,
  input logic [1:0]      run_i,
  input logic [1:0]      flag_clr_i,
  input logic [2*CW-1:0] cnt_o,
  input logic [4*CW-1:0] rise_lat_o,
  input logic [4*CW-1:0] fall_lat_o,
  input logic [1:0]      cap_flag_o,
  input logic [1:0]      rise_v,
  input logic [1:0]      en_eff,
  input logic [1:0]      reload_v
);
  localparam int unsigned LW = 2 * CW;
  localparam logic [CW-1:0] ONE = CW'(1);

  // R7
  flag0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o[0] && !flag_clr_i[0]) |=> cap_flag_o[0]);

  // R7
  flag1_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_flag_o[1] && !flag_clr_i[1]) |=> cap_flag_o[1]);

  // R3
  rise0_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rise_v[0] && en_eff[0]) |=> $stable(rise_lat_o[LW-1:0]));

  // R8
  count0_dec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cascade_i && run_i[0] && !reload_v[0] && cnt_o[CW-1:0] != '0)
    |=> (cnt_o[CW-1:0] == $past(cnt_o[CW-1:0]) - ONE));

  // R10
  upper_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cascade_i && run_i[0] && !reload_v[0] && cnt_o[CW-1:0] != '0)
    |=> $stable(cnt_o[LW-1:CW]));

  // R11
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rise_v[0] && en_eff[0] && !cascade_i) |=> (rise_lat_o[LW-1:CW] == '0));

  // R12
  ch1_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cascade_i |=> ($stable(rise_lat_o[2*LW-1:LW]) && $stable(fall_lat_o[2*LW-1:LW])));
endmodule

bind cap_capture_unit cap_capture_chk #(.CW(CW)) i_cap_capture_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cascade_i  (cascade_i),
  .run_i      (run_i),
  .flag_clr_i (flag_clr_i),
  .cnt_o      (cnt_o),
  .rise_lat_o (rise_lat_o),
  .fall_lat_o (fall_lat_o),
  .cap_flag_o (cap_flag_o),
  .rise_v     (rise_v),
  .en_eff     (en_eff),
  .reload_v   (reload_v)
);

// File: tb/test_cap_capture_unit.sv
`timescale 1ns/1ps
module test_cap_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  run, cap_en, rld_en, rie, fie, clr, cap;
  logic [31:0] period;
  logic        cascade;
  logic [31:0] cnt;
  logic [63:0] rlat, flat;
  logic [1:0]  flag;

  int    n_chk = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string ptag = "R1";
  logic [31:0] lfsr = 32'h1ACE_B00C;

  always #5 clk = ~clk;

  cap_capture_unit i_cap_capture_unit (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .period_i(period),
    .cascade_i(cascade), .cap_en_i(cap_en), .reload_en_i(rld_en),
    .rise_ie_i(rie), .fall_ie_i(fie), .flag_clr_i(clr), .cap_i(cap),
    .cnt_o(cnt), .rise_lat_o(rlat), .fall_lat_o(flat), .cap_flag_o(flag)
  );

  // Behavioural reference, stepped on every rising clock edge
  logic [15:0] m_c [2];
  logic [31:0] m_rl [2];
  logic [31:0] m_fl [2];
  logic [1:0]  m_flag;
  logic [1:0]  m_h [3];   // input history: [0] newest sample

  always @(posedge clk or negedge rst_n) begin : model
    logic [1:0]  rs, fs, en;
    logic [31:0] v [2];
    logic [31:0] full;
    if (!rst_n) begin
      m_c[0] = 0; m_c[1] = 0; m_rl[0] = 0; m_rl[1] = 0;
      m_fl[0] = 0; m_fl[1] = 0; m_flag = 0;
      m_h[0] = 0; m_h[1] = 0; m_h[2] = 0;
    end else begin
      en[0] = cap_en[0];
      en[1] = cap_en[1] & ~cascade;
      rs = m_h[1] & ~m_h[2] & en;
      fs = ~m_h[1] & m_h[2] & en;
      v[0] = cascade ? {m_c[1], m_c[0]} : {16'h0, m_c[0]};
      v[1] = {16'h0, m_c[1]};
      for (int ch = 0; ch < 2; ch++) begin
        if (rs[ch]) m_rl[ch] = v[ch];
        if (fs[ch]) m_fl[ch] = v[ch];
      end
      m_flag = (rs & rie) | (fs & fie) | (m_flag & ~clr);
      if (cascade) begin
        full = {m_c[1], m_c[0]};
        if (rs[0] && rld_en[0]) full = period;
        else if (run[0]) full = (full == 0) ? period : full - 1;
        m_c[1] = full[31:16];
        m_c[0] = full[15:0];
      end else begin
        for (int ch = 0; ch < 2; ch++) begin
          if (rs[ch] && rld_en[ch]) m_c[ch] = period[ch*16 +: 16];
          else if (run[ch]) m_c[ch] = (m_c[ch] == 0) ? period[ch*16 +: 16] : m_c[ch] - 1;
        end
      end
      m_h[2] = m_h[1];
      m_h[1] = m_h[0];
      m_h[0] = cap;
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Compare every output on every clock, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk({ptag, " counters"}, {32'h0, cnt}, {32'h0, m_c[1], m_c[0]});
      chk({ptag, " rising latches"}, rlat, {m_rl[1], m_rl[0]});
      chk({ptag, " falling latches"}, flat, {m_fl[1], m_fl[0]});
      chk({ptag, " flags"}, {62'h0, flag}, {62'h0, m_flag});
    end
  end

  task automatic stim(input int n, input int dens, input int clr_rate);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      if (int'(lfsr[7:0])   < dens) cap[0] = ~cap[0];
      if (int'(lfsr[23:16]) < dens) cap[1] = ~cap[1];
      clr = (int'(lfsr[15:8]) < clr_rate) ? lfsr[25:24] : 2'b00;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; run = 2'b11; period = {16'd23, 16'd37}; cascade = 1'b0;
    cap_en = 2'b11; rld_en = 2'b00; rie = 2'b11; fie = 2'b10; clr = 2'b00; cap = 2'b00;
    // R1: reset dominates while inputs move
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      cap = ~cap;
    end
    @(negedge clk);
    chk("R1 reset counters", {32'h0, cnt}, 64'h0);
    chk("R1 reset rising latches", rlat, 64'h0);
    chk("R1 reset falling latches", flat, 64'h0);
    chk("R1 reset flags", {62'h0, flag}, 64'h0);
    cap = 2'b00;
    rst_n = 1'b1;
    ptag = "R2 R8";
    repeat (10) @(negedge clk);

    // R2: two-stage delay, capture on the third edge
    cap[0] = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk("R2 latch before capture edge", {32'h0, rlat[31:0]}, 64'h0);
    @(negedge clk);
    chk("R2 latch after capture edge", {32'h0, rlat[31:0]}, {32'h0, m_rl[0]});
    chk("R2 captured value nonzero", {63'h0, (rlat[31:0] != 0)}, 64'h1);
    repeat (5) @(negedge clk);

    ptag = "R3 R4 R6 R8 R11";
    stim(4000, 24, 4);

    ptag = "R5 R8 stopped";
    cap_en = 2'b00; run = 2'b01;
    stim(1000, 40, 0);
    chk("R5 flags untouched", {62'h0, flag}, {62'h0, m_flag});

    ptag = "R7 R6";
    cap_en = 2'b11; run = 2'b11; fie = 2'b11;
    stim(2000, 30, 40);

    ptag = "R9";
    rld_en = 2'b11;
    stim(3000, 20, 8);

    // Enter cascade through a forced reload of the joined counter
    ptag = "R9 R10 R12";
    cascade = 1'b1; rld_en = 2'b01; period = {16'd1, 16'd9}; cap = 2'b00;
    repeat (6) @(negedge clk);
    cap[0] = 1'b1;
    repeat (6) @(negedge clk);
    chk("R9 cascade reload", {32'h0, cnt}, {32'h0, m_c[1], m_c[0]});
    ptag = "R10 R11 R12";
    rld_en = 2'b00;
    stim(66000, 3, 2);

    ptag = "R9 R11 R12 cascade reload";
    rld_en = 2'b11;
    stim(2000, 20, 6);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule